// File: doc/BRIEF.md
# Two's-Complement Adder-Subtractor with Relational Decode

This combinational unit adds or subtracts two WIDTH-bit operands held in two's-complement form. One control input picks the operation. For subtraction the unit complements the second operand bit by bit and feeds a one into the carry input of the lowest bit, so a single ripple-carry chain serves both operations.

Next to the WIDTH-bit result the unit gives four condition flags: zero, negative, carry out and signed overflow. When a subtraction is selected, a decoder turns those flags into ten relational outputs, six for signed operands and four for unsigned ones. A single subtraction therefore tells a datapath how the two operands order under either interpretation, with no separate comparator. During an addition all relational outputs are held low.

Top module: `addsub_cmp`

## Requirements
- R1: With `sub_en` = 0, `result` equals (`opnd_a` + `opnd_b`) modulo 2^WIDTH, and `flag_c` is the bit that falls out above the top result bit.
- R2: With `sub_en` = 1, `result` equals (`opnd_a` − `opnd_b`) modulo 2^WIDTH, and `flag_c` = 1 exactly when `opnd_a` ≥ `opnd_b` read as unsigned values (no borrow).
- R3: `flag_z` = 1 exactly when every bit of `result` is 0.
- R4: `flag_n` equals bit WIDTH−1 of `result`.
- R5: `flag_v` = 1 exactly when the signed sum or difference lies outside −2^(WIDTH−1) to 2^(WIDTH−1)−1. Adding the largest positive value to itself must set it.
- R6: With `sub_en` = 1 and both operands read as signed, `cmp_lt`, `cmp_le`, `cmp_eq`, `cmp_ne`, `cmp_ge` and `cmp_gt` give the truth of a<b, a≤b, a=b, a≠b, a≥b and a>b.
- R7: With `sub_en` = 1 and both operands read as unsigned, `cmp_ltu`, `cmp_leu`, `cmp_geu` and `cmp_gtu` give the truth of a<b, a≤b, a≥b and a>b.
- R8: With `sub_en` = 0 all ten relational outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand (subtrahend when subtracting) |
| sub_en | input | 1 | 1 = compute a−b, 0 = compute a+b |
| result | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| flag_z | output | 1 | Result is all zeros |
| flag_n | output | 1 | Top bit of the result |
| flag_c | output | 1 | Carry out of the top adder position |
| flag_v | output | 1 | Signed overflow |
| cmp_lt | output | 1 | Signed less-than |
| cmp_le | output | 1 | Signed less-or-equal |
| cmp_eq | output | 1 | Equal |
| cmp_ne | output | 1 | Not equal |
| cmp_ge | output | 1 | Signed greater-or-equal |
| cmp_gt | output | 1 | Signed greater-than |
| cmp_ltu | output | 1 | Unsigned less-than |
| cmp_leu | output | 1 | Unsigned less-or-equal |
| cmp_geu | output | 1 | Unsigned greater-or-equal |
| cmp_gtu | output | 1 | Unsigned greater-than |

## Verification
Random operand pairs with mixed signs test the plain adder and the decode over the whole range. A second set of pairs is drawn mostly from extreme values: zero, one, all ones, the most negative and the most positive value. These separate the signed and unsigned orderings, which disagree whenever exactly one operand has its top bit set, and they reach both overflow directions. Directed pairs cover 0−0, MIN−1, MAX+1, MAX+MAX and equal operands. On these the overflow, borrow and equality paths must each produce their boundary value, and an error that swaps carry polarity or drops the zero term from LE/GT would show.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } cc_flags_t;

    typedef struct packed {
        logic lt;
        logic le;
        logic eq;
        logic ne;
        logic ge;
        logic gt;
        logic ltu;
        logic leu;
        logic geu;
        logic gtu;
    } rel_t;

    function automatic logic bit_sum(input logic a, input logic b, input logic ci);
        return a ^ b ^ ci;
    endfunction

    function automatic logic bit_carry(input logic a, input logic b, input logic ci);
        return (a & b) | (ci & (a ^ b));
    endfunction

endpackage

// File: rtl/addsub_operand.sv
module addsub_operand #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_in,
    input  logic             invert,
    output logic [WIDTH-1:0] opnd_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_inv
        assign opnd_out[i] = opnd_in[i] ^ invert;
    end
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple
    import addsub_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             c_into_msb,
    output logic             cout
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        assign sum[i]     = bit_sum(x[i], y[i], chain[i]);
        assign chain[i+1] = bit_carry(x[i], y[i], chain[i]);
    end

    assign c_into_msb = chain[MSB];
    assign cout       = chain[WIDTH];
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
    import addsub_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] sum,
    input  logic             c_into_msb,
    input  logic             cout,
    output cc_flags_t        flags
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        flags.z = ~|sum;
        flags.n = sum[MSB];
        flags.c = cout;
        flags.v = c_into_msb ^ cout;
    end
endmodule

// File: rtl/addsub_reldec.sv
module addsub_reldec
    import addsub_pkg::*;
(
    input  cc_flags_t flags,
    input  logic      enable,
    output rel_t      rel
);
    logic below;
    logic below_or_eq;

    always_comb begin
        below       = flags.n ^ flags.v;
        below_or_eq = flags.z | below;
        rel         = '0;
        if (enable) begin
            rel.lt  = below;
            rel.le  = below_or_eq;
            rel.eq  = flags.z;
            rel.ne  = ~flags.z;
            rel.ge  = ~below;
            rel.gt  = ~below_or_eq;
            rel.ltu = ~flags.c;
            rel.leu = ~flags.c | flags.z;
            rel.geu = flags.c;
            rel.gtu = flags.c & ~flags.z;
        end
    end
endmodule

// File: rtl/addsub_cmp.sv
module addsub_cmp
    import addsub_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             sub_en,
    output logic [WIDTH-1:0] result,
    output logic             flag_z,
    output logic             flag_n,
    output logic             flag_c,
    output logic             flag_v,
    output logic             cmp_lt,
    output logic             cmp_le,
    output logic             cmp_eq,
    output logic             cmp_ne,
    output logic             cmp_ge,
    output logic             cmp_gt,
    output logic             cmp_ltu,
    output logic             cmp_leu,
    output logic             cmp_geu,
    output logic             cmp_gtu
);
    logic [WIDTH-1:0] b_eff;
    logic             c_msb;
    logic             c_out;
    cc_flags_t        cc;
    rel_t             rel;

    addsub_operand #(.WIDTH(WIDTH)) i_operand (
        .opnd_in  (opnd_b),
        .invert   (sub_en),
        .opnd_out (b_eff)
    );

    addsub_ripple #(.WIDTH(WIDTH)) i_ripple (
        .x          (opnd_a),
        .y          (b_eff),
        .cin        (sub_en),
        .sum        (result),
        .c_into_msb (c_msb),
        .cout       (c_out)
    );

    addsub_flags #(.WIDTH(WIDTH)) i_flags (
        .sum        (result),
        .c_into_msb (c_msb),
        .cout       (c_out),
        .flags      (cc)
    );

    addsub_reldec i_reldec (
        .flags  (cc),
        .enable (sub_en),
        .rel    (rel)
    );

    assign flag_z  = cc.z;
    assign flag_n  = cc.n;
    assign flag_c  = cc.c;
    assign flag_v  = cc.v;
    assign cmp_lt  = rel.lt;
    assign cmp_le  = rel.le;
    assign cmp_eq  = rel.eq;
    assign cmp_ne  = rel.ne;
    assign cmp_ge  = rel.ge;
    assign cmp_gt  = rel.gt;
    assign cmp_ltu = rel.ltu;
    assign cmp_leu = rel.leu;
    assign cmp_geu = rel.geu;
    assign cmp_gtu = rel.gtu;
endmodule

// File: rtl/addsub_cmp_chk.sv
module addsub_cmp_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic             sub_en,
    input logic [WIDTH-1:0] result,
    input logic             flag_z,
    input logic             flag_n,
    input logic             flag_c,
    input logic             flag_v,
    input logic             cmp_lt,
    input logic             cmp_le,
    input logic             cmp_eq,
    input logic             cmp_ne,
    input logic             cmp_ge,
    input logic             cmp_gt,
    input logic             cmp_ltu,
    input logic             cmp_leu,
    input logic             cmp_geu,
    input logic             cmp_gtu
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] wide_sum;
    logic           b_sign;
    logic           v_ref;
    logic [9:0]     rel_bits;

    always_comb begin
        wide_sum = {1'b0, opnd_a} + {1'b0, opnd_b};
        b_sign   = sub_en ? ~opnd_b[MSB] : opnd_b[MSB];
        v_ref    = (opnd_a[MSB] == b_sign) && (result[MSB] != opnd_a[MSB]);
        rel_bits = {cmp_lt, cmp_le, cmp_eq, cmp_ne, cmp_ge,
                    cmp_gt, cmp_ltu, cmp_leu, cmp_geu, cmp_gtu};

        if (!sub_en) begin
            p_add_sum_r1: assert ({flag_c, result} == wide_sum);
            p_idle_rel_r8: assert (rel_bits == '0);
        end
        if (sub_en) begin
            p_sub_diff_r2: assert (result == opnd_a - opnd_b);
            p_sub_borrow_r2: assert (flag_c == (opnd_a >= opnd_b));
            p_signed_lt_r6: assert (cmp_lt == ($signed(opnd_a) < $signed(opnd_b)));
            p_equal_r6: assert (cmp_eq == (opnd_a == opnd_b));
            p_unsigned_lt_r7: assert (cmp_ltu == (opnd_a < opnd_b));
        end
        p_zero_flag_r3: assert (flag_z == (result == '0));
        p_neg_flag_r4: assert (flag_n == result[MSB]);
        p_overflow_r5: assert (flag_v == v_ref);
    end
endmodule

bind addsub_cmp addsub_cmp_chk #(.WIDTH(WIDTH)) i_chk (
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .sub_en  (sub_en),
    .result  (result),
    .flag_z  (flag_z),
    .flag_n  (flag_n),
    .flag_c  (flag_c),
    .flag_v  (flag_v),
    .cmp_lt  (cmp_lt),
    .cmp_le  (cmp_le),
    .cmp_eq  (cmp_eq),
    .cmp_ne  (cmp_ne),
    .cmp_ge  (cmp_ge),
    .cmp_gt  (cmp_gt),
    .cmp_ltu (cmp_ltu),
    .cmp_leu (cmp_leu),
    .cmp_geu (cmp_geu),
    .cmp_gtu (cmp_gtu)
);

// File: tb/test_addsub_cmp.sv
module test_addsub_cmp;
    localparam int  W          = 32;
    localparam time CLK_PERIOD = 10ns;
    localparam int  N_RAND     = 600;

    localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONES = '1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a, b;
    logic         sub;
    logic [W-1:0] res;
    logic         fz, fn, fc, fv;
    logic         lt, le, eq, ne, ge, gt, ltu, leu, geu, gtu;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addsub_cmp #(.WIDTH(W)) i_addsub_cmp (
        .opnd_a (a), .opnd_b (b), .sub_en (sub),
        .result (res),
        .flag_z (fz), .flag_n (fn), .flag_c (fc), .flag_v (fv),
        .cmp_lt (lt), .cmp_le (le), .cmp_eq (eq), .cmp_ne (ne),
        .cmp_ge (ge), .cmp_gt (gt),
        .cmp_ltu (ltu), .cmp_leu (leu), .cmp_geu (geu), .cmp_gtu (gtu)
    );

    function automatic logic exp_v(input logic [W-1:0] x, input logic [W-1:0] y, input logic s);
        longint sx = longint'($signed(x));
        longint sy = longint'($signed(y));
        longint r  = s ? sx - sy : sx + sy;
        longint hi = longint'($signed(MAXP));
        longint lo = longint'($signed(MINN));
        return (r > hi) || (r < lo);
    endfunction

    function automatic logic [W-1:0] pick(input int unsigned sel, input int unsigned raw);
        case (sel % 8)
            0: return '0;
            1: return 1;
            2: return ONES;
            3: return MAXP;
            4: return MINN;
            5: return MAXP - 1;
            6: return MINN + 1;
            default: return raw;
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h exp %h (a=%h b=%h sub=%0b)",
                     req, what, got, exp, a, b, sub);
        end
    endtask

    task automatic run(input logic [W-1:0] x, input logic [W-1:0] y, input logic s);
        logic [W:0]   wsum;
        logic [W-1:0] r_exp;
        logic [5:0]   s_exp;
        logic [3:0]   u_exp;
        @(negedge clk);
        a = x; b = y; sub = s;
        #1;
        if (!s) begin
            wsum = {1'b0, x} + {1'b0, y};
            r_exp = wsum[W-1:0];
            chk("R1", "sum", 64'(res), 64'(r_exp));
            chk("R1", "carry", 64'(fc), 64'(wsum[W]));
            chk("R8", "rel idle", 64'({lt, le, eq, ne, ge, gt, ltu, leu, geu, gtu}), 64'(0));
        end else begin
            r_exp = x - y;
            chk("R2", "diff", 64'(res), 64'(r_exp));
            chk("R2", "no-borrow", 64'(fc), 64'(x >= y));
            s_exp = {$signed(x) <  $signed(y), $signed(x) <= $signed(y), x == y,
                     x != y, $signed(x) >= $signed(y), $signed(x) > $signed(y)};
            u_exp = {x < y, x <= y, x >= y, x > y};
            chk("R6", "signed rel", 64'({lt, le, eq, ne, ge, gt}), 64'(s_exp));
            chk("R7", "unsigned rel", 64'({ltu, leu, geu, gtu}), 64'(u_exp));
        end
        chk("R3", "zero", 64'(fz), 64'(r_exp == '0));
        chk("R4", "neg", 64'(fn), 64'(r_exp[W-1]));
        chk("R5", "ovf", 64'(fv), 64'(exp_v(x, y, s)));
    endtask

    initial begin
        int unsigned seed_dummy;
        a = '0; b = '0; sub = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // state after reset with idle inputs: zero sum, Z set (R3), no compares (R8)
        @(negedge clk);
        chk("R3", "reset zero", 64'(fz), 64'(1));
        chk("R8", "reset rel", 64'({lt, le, eq, ne, ge, gt, ltu, leu, geu, gtu}), 64'(0));

        // directed corners
        run('0, '0, 1'b1);          // 0-0: Z, C=1, EQ (R2 R6 R7)
        run(MINN, 1, 1'b1);         // MIN-1: V set (R5)
        run(MAXP, 1, 1'b0);         // MAX+1: V set, N set (R5 R4)
        run(MAXP, MAXP, 1'b0);      // MAX+MAX: V set (R5)
        run(32'h1234_5678, 32'h1234_5678, 1'b1); // equal (R6 R7)
        run('0, 1, 1'b1);           // borrow, unsigned below (R7)
        run(ONES, 1, 1'b0);         // wraps to zero with carry (R1 R3)
        run(MINN, MAXP, 1'b1);      // signed below, unsigned above (R6 R7)
        run(1, MINN, 1'b1);         // V on subtract (R5)

        seed_dummy = $urandom(32'd20240611);
        for (int i = 0; i < N_RAND; i++) begin
            logic [W-1:0] x, y;
            if (i % 2 == 0) begin
                x = $urandom; y = $urandom;
            end else begin
                x = pick($urandom, $urandom);
                y = pick($urandom, $urandom);
            end
            run(x, y, 1'($urandom));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: all requirements, got timeout exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule